// File: doc/BRIEF.md
# Host Status/Control Register Bank

This block is the byte-wide register bank that a host processor uses to steer a small Ethernet switch controller. It holds four registers: network control, network status, transmit control and receive control. A synchronous strobe bus reaches them: address, write data, a write strobe, a read strobe and registered read data. Sideband outputs carry the stored control fields to the MAC and transmit engine. Sideband inputs carry completion events back from the engine.

Two bits clear themselves. The software reset bit starts a timed pulse whose length comes from the clock frequency and a width in microseconds. The transmit request bit drops when the transmit engine reports that it has finished all of its work. The status register holds two sticky completion flags, one for each packet index. The host chooses at run time how these flags are cleared: a read of the status register clears them, or only a write of 1 to a flag clears that flag.

Top module: `host_regbank`

## Requirements
- R1: After rst_ni is released, every register reads 0x00, rdata_o is 0x00 and every sideband output is 0.
- R2: Registers sit at addresses 0x00 (network control), 0x01 (status), 0x02 (transmit control) and 0x05 (receive control). Any other address reads 0x00 and a write to it changes nothing. Reserved bits read 0.
- R3: A read strobe in one cycle puts the addressed register's value on rdata_o in the next cycle. rdata_o holds that value until the next read.
- R4: In network control, bit 1 is a read/write loopback enable driven on loopback_o. Bit 5 is a read/write clear-policy select: 0 means clear-on-read, 1 means write-one-to-clear.
- R5: Writing 1 to network control bit 0 raises soft_rst_o for exactly CLK_MHZ*RST_US cycles, and bit 0 reads 1 while it is high. Writes to bit 0 while the pulse runs, whether 0 or 1, neither cut it short nor extend it.
- R6: Status bit 2 sets when tx1_done_i pulses and status bit 3 sets when tx2_done_i pulses. Each bit stays set until it is cleared.
- R7: With the policy bit at 0, a read of status returns the current flags and then clears them all. Writing 1 to a flag also clears it.
- R8: With the policy bit at 1, a read of status leaves the flags unchanged. Writing 1 to a flag clears only that flag.
- R9: When a completion event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: In transmit control, bit 0 is the transmit request on tx_req_o. A write sets it and a tx_all_done_i pulse clears it. Bit 1 drives crc_dis1_o and bit 3 drives crc_dis2_o.
- R11: In receive control, bit 0 drives rx_en_o, bit 1 drives promisc_o, bit 3 drives mcast_all_o and bit 7 drives hash_all_o. All four are read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| tx1_done_i | input | 1 | Packet index 1 transmit completion pulse |
| tx2_done_i | input | 1 | Packet index 2 transmit completion pulse |
| tx_all_done_i | input | 1 | Whole transmit request completion pulse |
| soft_rst_o | output | 1 | Timed software reset pulse |
| loopback_o | output | 1 | Loopback test mode enable |
| tx_req_o | output | 1 | Transmit request |
| crc_dis1_o | output | 1 | Disable CRC append, packet index 1 |
| crc_dis2_o | output | 1 | Disable CRC append, packet index 2 |
| rx_en_o | output | 1 | Receive enable |
| promisc_o | output | 1 | Promiscuous mode |
| mcast_all_o | output | 1 | Pass all multicast |
| hash_all_o | output | 1 | Accept all hash-table addresses |

## Verification
The hardest cases to reach are collisions between a host access and a completion event in the same cycle. One is a status read that both returns the old flags and clears them while a new event sets a flag. The other is a write-one-to-clear that lands on the cycle a flag is set. The stimulus drives the read or write strobe and the done pulse on the same falling edge, in both clear policies. It then reads status twice, so that the captured value and the value left behind are each compared. For the reset pulse, writes to bit 0 are injected partway through it, and the high cycles are still counted one by one.

// File: rtl/host_regbank_pkg.sv
package host_regbank_pkg;
  localparam int DATA_W = 8;

  localparam logic [7:0] A_NET_CTL = 8'h00;
  localparam logic [7:0] A_NET_STS = 8'h01;
  localparam logic [7:0] A_TX_CTL  = 8'h02;
  localparam logic [7:0] A_RX_CTL  = 8'h05;

  // network control
  localparam int B_SRST  = 0;
  localparam int B_LBK   = 1;
  localparam int B_CLRW1 = 5;
  // status
  localparam int B_DONE1 = 2;
  localparam int B_DONE2 = 3;
  // transmit control
  localparam int B_TXREQ = 0;
  localparam int B_NCRC1 = 1;
  localparam int B_NCRC2 = 3;
  // receive control
  localparam int B_RXEN  = 0;
  localparam int B_PROM  = 1;
  localparam int B_MCALL = 3;
  localparam int B_HASH  = 7;

  typedef struct packed {
    logic hash_all;
    logic mcast_all;
    logic promisc;
    logic rx_en;
  } rx_cfg_t;
endpackage

// File: rtl/hrb_rst_timer.sv
module hrb_rst_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (start_i) begin
        act_q <= 1'b1;
        cnt_q <= CNT_W'(CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/hrb_status.sv
module hrb_status #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] wclr_i,
  input  logic         rclr_i,
  output logic [N-1:0] sts_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   q <= 1'b0;
      else if (set_i[i])             q <= 1'b1;  // set beats clear
      else if (wclr_i[i] || rclr_i)  q <= 1'b0;
    end
    assign sts_o[i] = q;
  end
endmodule

// File: rtl/host_regbank.sv
module host_regbank
  import host_regbank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CLK_MHZ = 200,
  parameter int RST_US  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx1_done_i,
  input  logic              tx2_done_i,
  input  logic              tx_all_done_i,
  output logic              soft_rst_o,
  output logic              loopback_o,
  output logic              tx_req_o,
  output logic              crc_dis1_o,
  output logic              crc_dis2_o,
  output logic              rx_en_o,
  output logic              promisc_o,
  output logic              mcast_all_o,
  output logic              hash_all_o
);
  localparam int RST_CYCLES = CLK_MHZ * RST_US;

  logic sel_ctl, sel_sts, sel_tx, sel_rx;
  assign sel_ctl = (addr_i == ADDR_W'(A_NET_CTL));
  assign sel_sts = (addr_i == ADDR_W'(A_NET_STS));
  assign sel_tx  = (addr_i == ADDR_W'(A_TX_CTL));
  assign sel_rx  = (addr_i == ADDR_W'(A_RX_CTL));

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[6], wdata_i[4]};

  // network control
  logic lbk_q, clr_w1c_q, srst_act;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lbk_q     <= 1'b0;
      clr_w1c_q <= 1'b0;
    end else if (we_i && sel_ctl) begin
      lbk_q     <= wdata_i[B_LBK];
      clr_w1c_q <= wdata_i[B_CLRW1];
    end
  end

  hrb_rst_timer #(.CYCLES(RST_CYCLES)) u_rst_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (we_i && sel_ctl && wdata_i[B_SRST]),
    .active_o(srst_act)
  );

  // status flags: [0] packet index 1, [1] packet index 2
  logic [1:0] sts_q;
  hrb_status #(.N(2)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({tx2_done_i, tx1_done_i}),
    .wclr_i ((we_i && sel_sts) ? {wdata_i[B_DONE2], wdata_i[B_DONE1]} : 2'b00),
    .rclr_i (re_i && sel_sts && !clr_w1c_q),
    .sts_o  (sts_q)
  );

  // transmit control
  logic txreq_q, ncrc1_q, ncrc2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txreq_q <= 1'b0;
      ncrc1_q <= 1'b0;
      ncrc2_q <= 1'b0;
    end else begin
      if (we_i && sel_tx) begin
        txreq_q <= wdata_i[B_TXREQ];
        ncrc1_q <= wdata_i[B_NCRC1];
        ncrc2_q <= wdata_i[B_NCRC2];
      end else if (tx_all_done_i) begin
        txreq_q <= 1'b0;
      end
    end
  end

  // receive control
  rx_cfg_t rx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0;
    end else if (we_i && sel_rx) begin
      rx_q.hash_all  <= wdata_i[B_HASH];
      rx_q.mcast_all <= wdata_i[B_MCALL];
      rx_q.promisc   <= wdata_i[B_PROM];
      rx_q.rx_en     <= wdata_i[B_RXEN];
    end
  end

  // read path
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_ctl) begin
      rd_mux[B_SRST]  = srst_act;
      rd_mux[B_LBK]   = lbk_q;
      rd_mux[B_CLRW1] = clr_w1c_q;
    end else if (sel_sts) begin
      rd_mux[B_DONE1] = sts_q[0];
      rd_mux[B_DONE2] = sts_q[1];
    end else if (sel_tx) begin
      rd_mux[B_TXREQ] = txreq_q;
      rd_mux[B_NCRC1] = ncrc1_q;
      rd_mux[B_NCRC2] = ncrc2_q;
    end else if (sel_rx) begin
      rd_mux[B_HASH]  = rx_q.hash_all;
      rd_mux[B_MCALL] = rx_q.mcast_all;
      rd_mux[B_PROM]  = rx_q.promisc;
      rd_mux[B_RXEN]  = rx_q.rx_en;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  assign soft_rst_o  = srst_act;
  assign loopback_o  = lbk_q;
  assign tx_req_o    = txreq_q;
  assign crc_dis1_o  = ncrc1_q;
  assign crc_dis2_o  = ncrc2_q;
  assign rx_en_o     = rx_q.rx_en;
  assign promisc_o   = rx_q.promisc;
  assign mcast_all_o = rx_q.mcast_all;
  assign hash_all_o  = rx_q.hash_all;
endmodule

// File: rtl/host_regbank_chk.sv
module host_regbank_chk
  import host_regbank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CLK_MHZ = 200,
  parameter int RST_US  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              tx1_done_i,
  input logic              tx2_done_i,
  input logic              tx_all_done_i,
  input logic              tx_req_o,
  input logic              soft_rst_o,
  input logic [1:0]        sts_q,
  input logic              clr_w1c_q
);
  localparam int RST_CYCLES = CLK_MHZ * RST_US;

  logic [31:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hi_cnt <= '0;
    else if (soft_rst_o) hi_cnt <= hi_cnt + 1;
    else                 hi_cnt <= '0;
  end

  logic mapped;
  assign mapped = (addr_i == ADDR_W'(A_NET_CTL)) || (addr_i == ADDR_W'(A_NET_STS)) ||
                  (addr_i == ADDR_W'(A_TX_CTL))  || (addr_i == ADDR_W'(A_RX_CTL));

  assert_rst_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt <= RST_CYCLES);
  assert_rst_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(soft_rst_o) |-> hi_cnt == RST_CYCLES);
  assert_done1_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx1_done_i |=> sts_q[0]);
  assert_done2_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx2_done_i |=> sts_q[1]);
  assert_cor_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == ADDR_W'(A_NET_STS) && !clr_w1c_q && !tx1_done_i && !tx2_done_i)
      |=> sts_q == 2'b00);
  assert_w1c_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !we_i && addr_i == ADDR_W'(A_NET_STS) && clr_w1c_q)
      |=> (sts_q & $past(sts_q)) == $past(sts_q));
  assert_txreq_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_all_done_i && !(we_i && addr_i == ADDR_W'(A_TX_CTL))) |=> !tx_req_o);
  assert_unmapped_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !mapped) |=> rdata_o == '0);
endmodule

bind host_regbank host_regbank_chk #(
  .ADDR_W (ADDR_W),
  .CLK_MHZ(CLK_MHZ),
  .RST_US (RST_US)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .we_i         (we_i),
  .re_i         (re_i),
  .rdata_o      (rdata_o),
  .tx1_done_i   (tx1_done_i),
  .tx2_done_i   (tx2_done_i),
  .tx_all_done_i(tx_all_done_i),
  .tx_req_o     (tx_req_o),
  .soft_rst_o   (soft_rst_o),
  .sts_q        (sts_q),
  .clr_w1c_q    (clr_w1c_q)
);

// File: tb/host_regbank_bench.sv
`timescale 1ns/1ps
module host_regbank_bench;
  localparam int PULSE = 200 * 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0, re_i = 1'b0;
  logic [7:0] rdata_o;
  logic       tx1_done_i = 1'b0, tx2_done_i = 1'b0, tx_all_done_i = 1'b0;
  logic       soft_rst_o, loopback_o, tx_req_o, crc_dis1_o, crc_dis2_o;
  logic       rx_en_o, promisc_o, mcast_all_o, hash_all_o;

  always #2.5 clk_i = ~clk_i;

  host_regbank u_host_regbank (.*);

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i); we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk_i); re_i = 1'b1; addr_i = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i); re_i = 1'b0;
  endtask

  task automatic pulse(input logic d1, input logic d2, input logic da);
    @(negedge clk_i); tx1_done_i = d1; tx2_done_i = d2; tx_all_done_i = da;
    @(negedge clk_i); tx1_done_i = 1'b0; tx2_done_i = 1'b0; tx_all_done_i = 1'b0;
  endtask

  // monitor: read data is valid one cycle after the strobe (R3)
  initial begin
    forever begin
      @(posedge clk_i);
      if (re_i) begin
        @(negedge clk_i);
        if (exp_q.size() == 0) chk(1, 0, "R3 unexpected read");
        else chk(rdata_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(rdata_o, 0, "R1 rdata");
    chk({soft_rst_o, loopback_o, tx_req_o, crc_dis1_o, crc_dis2_o,
         rx_en_o, promisc_o, mcast_all_o, hash_all_o}, 0, "R1 outputs");
    rd(8'h00, 8'h00, "R1 ctl"); rd(8'h01, 8'h00, "R1 sts");
    rd(8'h02, 8'h00, "R1 tx");  rd(8'h05, 8'h00, "R1 rx");

    // R4 / R2 reserved bits
    wr(8'h00, 8'h22);
    chk(loopback_o, 1, "R4 loopback_o");
    rd(8'h00, 8'h22, "R4 ctl readback");
    chk(rdata_o, 8'h22, "R3 hold");
    wr(8'h00, 8'hDE);
    rd(8'h00, 8'h02, "R2 ctl reserved");
    wr(8'h00, 8'h00);
    chk(loopback_o, 0, "R4 loopback off");

    // R11
    wr(8'h05, 8'hFF);
    rd(8'h05, 8'h8B, "R11 rx readback");
    chk({hash_all_o, mcast_all_o, promisc_o, rx_en_o}, 4'hF, "R11 rx outputs");
    wr(8'h05, 8'h02);
    chk({hash_all_o, mcast_all_o, promisc_o, rx_en_o}, 4'h2, "R11 promisc only");
    wr(8'h05, 8'h00);

    // R10
    wr(8'h02, 8'hFF);
    rd(8'h02, 8'h0B, "R10 tx readback");
    chk({tx_req_o, crc_dis2_o, crc_dis1_o}, 3'b111, "R10 tx outputs");
    pulse(1'b0, 1'b0, 1'b1);
    chk(tx_req_o, 0, "R10 req auto clear");
    rd(8'h02, 8'h0A, "R10 after done");
    wr(8'h02, 8'h00);

    // R2 unmapped
    wr(8'h03, 8'hFF); wr(8'h04, 8'hFF); wr(8'h06, 8'hFF);
    rd(8'h03, 8'h00, "R2 addr 3"); rd(8'h04, 8'h00, "R2 addr 4");
    rd(8'h06, 8'h00, "R2 addr 6");
    rd(8'h05, 8'h00, "R2 rx untouched"); rd(8'h00, 8'h00, "R2 ctl untouched");

    // R6 / R7 clear-on-read
    pulse(1'b1, 1'b0, 1'b0);
    rd(8'h01, 8'h04, "R6 done1 set");
    rd(8'h01, 8'h00, "R7 cleared by read");
    pulse(1'b0, 1'b1, 1'b0);
    wr(8'h01, 8'h08);
    rd(8'h01, 8'h00, "R7 write1 clear");
    pulse(1'b1, 1'b1, 1'b0);
    rd(8'h01, 8'h0C, "R6 both set");
    rd(8'h01, 8'h00, "R7 both cleared");

    // R8 write-one-to-clear
    wr(8'h00, 8'h20);
    pulse(1'b1, 1'b1, 1'b0);
    rd(8'h01, 8'h0C, "R8 first read");
    rd(8'h01, 8'h0C, "R8 read keeps");
    wr(8'h01, 8'h04);
    rd(8'h01, 8'h08, "R8 clear done1 only");
    wr(8'h01, 8'h08);
    rd(8'h01, 8'h00, "R8 clear done2");

    // R9 set beats write clear
    @(negedge clk_i); we_i = 1'b1; addr_i = 8'h01; wdata_i = 8'h04; tx1_done_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0; tx1_done_i = 1'b0;
    rd(8'h01, 8'h04, "R9 set vs w1c");
    wr(8'h01, 8'h04);
    // R9 set beats clear-on-read
    wr(8'h00, 8'h00);
    pulse(1'b1, 1'b0, 1'b0);
    @(negedge clk_i); re_i = 1'b1; addr_i = 8'h01; tx2_done_i = 1'b1;
    exp_q.push_back(8'h04); tag_q.push_back("R9 read captures old");
    @(negedge clk_i); re_i = 1'b0; tx2_done_i = 1'b0;
    rd(8'h01, 8'h08, "R9 set vs read clear");
    rd(8'h01, 8'h00, "R7 final clear");

    // R5 software reset
    wr(8'h00, 8'h01);
    n = 0;
    while (soft_rst_o && n < 3 * PULSE) begin
      n++;
      if (n == 500 || n == 700) begin
        we_i = 1'b1; addr_i = 8'h00; wdata_i = (n == 500) ? 8'h01 : 8'h00;
      end else we_i = 1'b0;
      @(negedge clk_i);
    end
    we_i = 1'b0;
    chk(n, PULSE, "R5 pulse width with writes");
    rd(8'h00, 8'h00, "R5 bit clears");
    wr(8'h00, 8'h01);
    rd(8'h00, 8'h01, "R5 bit reads 1");
    chk(soft_rst_o, 1, "R5 output high");
    n = 2;
    while (soft_rst_o && n < 3 * PULSE) begin n++; @(negedge clk_i); end
    chk(n, PULSE, "R5 pulse width");

    repeat (3) @(negedge clk_i);
    chk(exp_q.size(), 0, "R3 reads pending");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule